// File: doc/BRIEF.md
# Multi-Cycle Load/Store Processor Core

This block is a compact 32-bit load/store processor core. It advances through its work one stage per clock edge. Each instruction is first brought in from the instruction port. It is then decoded and its source registers are read. An execute step follows, then an optional data-memory step, then an optional register update. An instruction leaves out the stages it has no use for, so the number of cycles it takes depends on its kind. The core contains its own 32-entry register file, which has two read ports and one write port. Pipeline latches carry operands and results from one stage to the next.

Both memories are expected to answer in the same cycle. The instruction port presents the program counter and takes back one word. The data port presents an address, write data and a write strobe, and returns read data. The supported instructions are register add, add-immediate, signed set-less-than-immediate, load word and store word.

The sequencer has five named states. FETCH always goes to DECODE. DECODE goes to EXEC, or back to FETCH when the opcode is not recognised. EXEC goes to MEM for loads and stores and to WB for the arithmetic kinds. MEM goes to WB for a load and back to FETCH for a store. WB always goes to FETCH.

Top module: `core_top`

## Requirements
- R1: While reset is held low, and directly after it, the sequencer is in FETCH, the program counter is 0 (so `imem_addr` is 0) and `dmem_we` is 0.
- R2: In FETCH the word on `imem_rdata` is latched as the current instruction and the program counter becomes its old value plus 4. The program counter does not change in any other state.
- R3: The instruction fields are: opcode in bits 31:26, first source in 25:21, second source or immediate destination in 20:16, register-add destination in 15:11, and a 16-bit immediate in 15:0. An opcode other than 0x00, 0x08, 0x0A, 0x23 or 0x2B does nothing and goes back to FETCH after DECODE, for 2 cycles in total.
- R4: Opcode 0x00 writes the sum of its two source registers, modulo 2^32, to register bits 15:11. It takes 4 cycles: FETCH, DECODE, EXEC, WB.
- R5: Opcode 0x08 writes the first source plus the sign-extended immediate to register bits 20:16. It takes 4 cycles.
- R6: Opcode 0x0A writes 1 to register bits 20:16 when the first source is smaller than the sign-extended immediate as signed two's-complement numbers, and 0 otherwise. It takes 4 cycles.
- R7: Opcode 0x23 reads the data word at the first source plus the sign-extended immediate and writes it to register bits 20:16. It takes 5 cycles. The base register may also be the destination.
- R8: Opcode 0x2B writes the value of register bits 20:16 to the address formed as in R7. It takes 4 cycles (FETCH, DECODE, EXEC, MEM) and writes no register.
- R9: Register 0 always reads as 0, and a write to it has no effect.
- R10: `dmem_we` is 1 only in the MEM cycle of a store. In that cycle `dmem_addr` and `dmem_wdata` carry the store address and the store data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction word (the program counter) |
| imem_rdata | input | 32 | Instruction word returned in the same cycle |
| dmem_addr | output | 32 | Byte address for a data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Write strobe for the data memory |
| dmem_rdata | input | 32 | Load data returned in the same cycle |

## Verification
The cases that need care are those where a register read and a register update act on the same register within one instruction. In a load whose base register is also its destination, the base value has to survive until EXEC, while the loaded word replaces it in WB. Register 0 as a destination competes with the zero value that the read port forces for it. The directed program contains such a load, an add-immediate aimed at register 0, and a later store of register 0. A behavioural reference model, stepped stage by stage, judges each of them: every clock it compares the instruction address and the data strobe, address and data, and the data memory is compared once the program has finished.

// File: rtl/core_pkg.sv
package core_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB
    } stage_e;

    typedef enum logic [2:0] {
        K_ADD,
        K_ADDI,
        K_SLTI,
        K_LOAD,
        K_STORE,
        K_NONE
    } kind_e;

    localparam logic [5:0] OP_ADD   = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    function automatic kind_e classify(input logic [5:0] op);
        kind_e k;
        unique case (op)
            OP_ADD:   k = K_ADD;
            OP_ADDI:  k = K_ADDI;
            OP_SLTI:  k = K_SLTI;
            OP_LOAD:  k = K_LOAD;
            OP_STORE: k = K_STORE;
            default:  k = K_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic [AW-1:0]   ra_a,
    input  logic [AW-1:0]   ra_b,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] cells [NREG];

    // entry 0 is never written and is masked on read
    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            cells[wa] <= wd;
        end
    end

    always_comb begin
        rd_a = (ra_a == '0) ? '0 : cells[ra_a];
        rd_b = (ra_b == '0) ? '0 : cells[ra_b];
    end
endmodule

// File: rtl/core_alu.sv
module core_alu #(
    parameter int XLEN = 32
) (
    input  core_pkg::kind_e  kind,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic [XLEN-1:0]  imm,
    output logic [XLEN-1:0]  result
);
    import core_pkg::*;

    always_comb begin
        unique case (kind)
            K_ADD:   result = opa + opb;
            K_SLTI:  result = ($signed(opa) < $signed(imm)) ? XLEN'(1) : '0;
            K_NONE:  result = '0;
            default: result = opa + imm;   // addi, load and store address
        endcase
    end
endmodule

// File: rtl/core_seq.sv
module core_seq (
    input  logic                 clk,
    input  logic                 rst_n,
    input  core_pkg::kind_e      kind,
    output core_pkg::stage_e     state
);
    import core_pkg::*;

    stage_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = (kind == K_NONE) ? ST_FETCH : ST_EXEC;
            ST_EXEC:   nxt = (kind == K_LOAD || kind == K_STORE) ? ST_MEM : ST_WB;
            ST_MEM:    nxt = (kind == K_LOAD) ? ST_WB : ST_FETCH;
            ST_WB:     nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/core_top.sv
module core_top #(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);
    import core_pkg::*;

    localparam int AW = $clog2(NREG);

    stage_e          state;
    kind_e           kind;
    logic [XLEN-1:0] pc, ir, a_q, b_q, res_q, mdr_q;
    logic [XLEN-1:0] rd_a, rd_b, imm_x, alu_y, wb_data;
    logic [AW-1:0]   src_a, src_b, dst;
    logic            rf_we;

    assign kind  = classify(ir[31:26]);
    assign src_a = ir[21 +: AW];
    assign src_b = ir[16 +: AW];
    assign imm_x = {{(XLEN-16){ir[15]}}, ir[15:0]};

    core_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .state (state)
    );

    core_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk  (clk),
        .ra_a (src_a),
        .ra_b (src_b),
        .rd_a (rd_a),
        .rd_b (rd_b),
        .we   (rf_we),
        .wa   (dst),
        .wd   (wb_data)
    );

    core_alu #(.XLEN(XLEN)) u_alu (
        .kind   (kind),
        .opa    (a_q),
        .opb    (b_q),
        .imm    (imm_x),
        .result (alu_y)
    );

    // stage latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            ir    <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
            mdr_q <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir <= imem_rdata;
                    pc <= pc + XLEN'(4);
                end
                ST_DECODE: begin
                    a_q <= rd_a;
                    b_q <= rd_b;
                end
                ST_EXEC:  res_q <= alu_y;
                ST_MEM:   mdr_q <= dmem_rdata;
                default:  ;
            endcase
        end
    end

    // outputs and write-back controls
    always_comb begin
        imem_addr  = pc;
        dmem_addr  = res_q;
        dmem_wdata = b_q;
        dmem_we    = (state == ST_MEM) && (kind == K_STORE);
        rf_we      = (state == ST_WB);
        dst        = (kind == K_ADD) ? ir[11 +: AW] : src_b;
        wb_data    = (kind == K_LOAD) ? mdr_q : res_q;
    end
endmodule

// File: rtl/core_top_chk.sv
module core_top_chk #(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input core_pkg::stage_e  state,
    input logic [XLEN-1:0]   pc,
    input logic [XLEN-1:0]   ir,
    input logic [XLEN-1:0]   a_q,
    input logic              dmem_we
);
    import core_pkg::*;

    logic [5:0] op;
    assign op = ir[31:26];

    p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> (pc == $past(pc) + XLEN'(4)) && state == ST_DECODE);

    p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_FETCH |=> $stable(pc));

    p_unknown_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && classify(op) == K_NONE) |=> state == ST_FETCH);

    p_load_to_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEM && op == OP_LOAD) |=> state == ST_WB);

    p_store_skip_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEM && op == OP_STORE) |=> state == ST_FETCH);

    p_zero_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && ir[25:21] == 5'd0) |=> a_q == '0);

    p_we_store_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (state == ST_MEM && op == OP_STORE));
endmodule

bind core_top core_top_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .pc      (pc),
    .ir      (ir),
    .a_q     (a_q),
    .dmem_we (dmem_we)
);

// File: tb/tb_core_top.sv
module tb_core_top;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 130;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_add(input int rs, input int rt, input int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 11'd0};
    endfunction

    function automatic string op_tag(input logic [5:0] op);
        case (op)
            6'h00:   return "R4";
            6'h08:   return "R5";
            6'h0A:   return "R6";
            6'h23:   return "R7";
            6'h2B:   return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference state
    logic [31:0] m_rf [32];
    logic [31:0] m_pc, m_ir, m_res;
    int          m_stage;

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic model_compare();
        logic [5:0] op;
        bit         st;
        op = m_ir[31:26];
        st = (m_stage == 3) && (op == 6'h2B);
        chk(m_stage == 0 ? "R2" : op_tag(op), imem_addr, m_pc);
        chk("R10", {31'd0, dmem_we}, {31'd0, st});
        if (st) begin
            chk("R8", dmem_addr, m_res);
            chk("R8", dmem_wdata, m_rf[m_ir[20:16]]);
        end
    endtask

    task automatic model_step();
        logic [5:0]  op;
        logic [31:0] a, b;
        op = m_ir[31:26];
        a  = m_rf[m_ir[25:21]];
        b  = m_rf[m_ir[20:16]];
        case (m_stage)
            0: begin
                m_ir    = imem[m_pc[7:2]];
                m_pc    = m_pc + 32'd4;
                m_stage = 1;
            end
            1: m_stage = (op inside {6'h00, 6'h08, 6'h0A, 6'h23, 6'h2B}) ? 2 : 0;
            2: begin
                if (op == 6'h00)      m_res = a + b;
                else if (op == 6'h0A) m_res = ($signed(a) < $signed(sx(m_ir[15:0]))) ? 32'd1 : 32'd0;
                else                  m_res = a + sx(m_ir[15:0]);
                m_stage = (op == 6'h23 || op == 6'h2B) ? 3 : 4;
            end
            3: begin
                if (op == 6'h23) begin
                    m_res   = dmem[m_res[7:2]];
                    m_stage = 4;
                end else begin
                    m_stage = 0;
                end
            end
            default: begin
                if (op == 6'h00) begin
                    if (m_ir[15:11] != 5'd0) m_rf[m_ir[15:11]] = m_res;
                end else if (m_ir[20:16] != 5'd0) begin
                    m_rf[m_ir[20:16]] = m_res;
                end
                m_stage = 0;
            end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'hFC00_0000;
            dmem[i] = 32'h1111_0000 + 32'(i);
        end
        for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
        imem[0]  = enc_i(6'h08, 0, 1, 16'd5);        // r1 = 5
        imem[1]  = enc_i(6'h08, 0, 2, 16'hFFFD);     // r2 = -3
        imem[2]  = enc_add(1, 2, 3);                 // r3 = 2
        imem[3]  = enc_i(6'h0A, 2, 4, 16'd1);        // r4 = (-3 < 1) = 1
        imem[4]  = enc_i(6'h0A, 1, 5, 16'hFFFF);     // r5 = (5 < -1) = 0
        imem[5]  = enc_i(6'h08, 1, 0, 16'd7);        // write to r0 ignored
        imem[6]  = 32'hFC00_0123;                    // unknown opcode
        imem[7]  = enc_i(6'h2B, 0, 3, 16'd0);
        imem[8]  = enc_i(6'h2B, 0, 4, 16'd4);
        imem[9]  = enc_i(6'h2B, 0, 5, 16'd8);
        imem[10] = enc_i(6'h2B, 0, 0, 16'd12);
        imem[11] = enc_i(6'h08, 0, 6, 16'd16);       // r6 = 16
        imem[12] = enc_i(6'h23, 6, 6, 16'd4);        // r6 = mem[20], base == dest
        imem[13] = enc_i(6'h2B, 0, 6, 16'd24);
        imem[14] = enc_add(6, 6, 7);                 // wraps past 2^32
        imem[15] = enc_i(6'h2B, 0, 7, 16'd28);
        imem[16] = enc_i(6'h2B, 0, 1, 16'd32);
        dmem[5]  = 32'h9234_5678;
        m_pc = 0; m_ir = 0; m_res = 0; m_stage = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", imem_addr, 32'd0);
        chk("R1", {31'd0, dmem_we}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", imem_addr, 32'd4);   // one fetch after reset release, from address 0
        m_ir = imem[0]; m_pc = 32'd4; m_stage = 1;
        for (int c = 0; c < RUN_CYCLES; c++) begin
            model_compare();
            model_step();
            @(negedge clk);
        end

        chk("R4", dmem[0], 32'd2);
        chk("R6", dmem[1], 32'd1);
        chk("R6", dmem[2], 32'd0);
        chk("R9", dmem[3], 32'd0);
        chk("R7", dmem[6], 32'h9234_5678);
        chk("R4", dmem[7], 32'h2468_ACF0);
        chk("R5", dmem[8], 32'd5);
        chk("R8", dmem[4], 32'h1111_0004);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule